// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block receives asynchronous serial frames on a single line that rests high. Time is measured in quanta: a quantum tick input advances the receiver, and a programmable number of quanta makes up one bit time. A frame is one low start bit, a programmable number of data bits sent least significant bit first, an optional parity slot, and one high stop bit. Each bit is decided at a programmable sample point. The decision uses either the single quantum at that point, or a majority vote over that quantum and the two quanta before it.

The receiver presents each finished word with a one-cycle valid strobe. It also raises three event pulses, for noise, format error and frame finished, and each pulse has its own enable input. A busy flag shows that a frame is being received. A bus-idle indication is either forced high or derived from a run of passive bit times. The length of that run follows the frame length and depends on whether parity is enabled. All configuration inputs are expected to stay steady while a frame is in flight.

Top module: `osrx_receiver`

## Requirements
- R1: In single-sample mode (cfg_triple=0) each bit takes the line value at quantum index cfg_smp_pt of its bit time. Quantum 0 of the start bit is the tick on which the falling edge is first seen. Line values at other quanta have no effect on the received word.
- R2: In triple-sample mode (cfg_triple=1) each bit is the majority of the line values at quanta cfg_smp_pt-2, cfg_smp_pt-1 and cfg_smp_pt. A single differing quantum among those three does not change the received bit.
- R3: A noise event occurs when the three samples of a bit disagree in triple-sample mode. A noise event never occurs in single-sample mode.
- R4: A format error occurs when the stop bit is decided as 0. It is reported in the same cycle as the frame-finished pulse and the valid strobe of that frame.
- R5: At the stop-bit decision, rx_valid pulses for one cycle and rx_data holds the cfg_flen data bits in bits [cfg_flen-1:0], the first received bit in bit 0, with the upper bits 0.
- R6: With cfg_par_en=1, one extra bit slot follows the data bits and precedes the stop bit. Its value is not stored in rx_data.
- R7: A frame starts only on a high-to-low change between consecutive quantum samples while no frame is in progress. If the start bit is decided as 1, the frame is dropped without valid, finished or format pulses.
- R8: With cfg_idle_chk=1, bus_idle becomes 1 after cfg_flen+2 (no parity) or cfg_flen+3 (parity) consecutive bit times of high quanta, and not one quantum earlier. Any low quantum clears it on the next cycle.
- R9: With cfg_idle_chk=0, bus_idle is 1 at once, whatever the line does.
- R10: With cfg_busy_en=1, busy is high from the cycle after the start edge until the stop-bit decision. With cfg_busy_en=0, busy stays 0.
- R11: noise_pulse, fmt_err_pulse and fin_pulse are produced only while en_noise, en_fmt and en_fin are 1, respectively. rx_valid is not gated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| q_tick | input | 1 | One-cycle strobe marking one time quantum |
| rx_line | input | 1 | Serial receive line, passive high, synchronous to clk |
| cfg_triple | input | 1 | 1 = three samples with majority vote, 0 = one sample |
| cfg_smp_pt | input | QW | Sample point quantum index within the bit time |
| cfg_bit_q_m1 | input | QW | Quanta per bit time minus one |
| cfg_flen | input | FLW | Data bits per frame (1..DW) |
| cfg_par_en | input | 1 | Parity slot present |
| cfg_idle_chk | input | 1 | Enable line-based idle detection |
| cfg_busy_en | input | 1 | Let busy follow reception |
| en_noise | input | 1 | Enable noise pulse |
| en_fmt | input | 1 | Enable format error pulse |
| en_fin | input | 1 | Enable frame finished pulse |
| rx_data | output | DW | Received data word |
| rx_valid | output | 1 | One-cycle strobe, rx_data updated |
| bus_idle | output | 1 | Bus idle indication |
| busy | output | 1 | Frame reception in progress |
| noise_pulse | output | 1 | Noise event pulse |
| fmt_err_pulse | output | 1 | Format error pulse |
| fin_pulse | output | 1 | Frame finished pulse |

## Verification
The frame-finished pulse and the format error can fall in the same cycle. This is provoked by holding the whole stop bit low. A noise event can also fall on that same stop decision, which is provoked by flipping one quantum inside the stop bit's vote window. The bench counts every cycle in which a format error appears without a finished pulse while both are enabled, and expects that count to stay zero. It also checks that a format error is counted exactly once per bad frame, and that a glitched but valid stop bit gives noise without a format error.

// File: rtl/osrx_pkg.sv
package osrx_pkg;

   typedef enum logic [1:0] {
      ST_HUNT = 2'd0,
      ST_RECV = 2'd1
   } osrx_state_e;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/osrx_sampler.sv
module osrx_sampler #(
   parameter bit TRI_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic line,
   input  logic tri_mode,
   output logic bit_val,
   output logic bit_noise,
   output logic prev_smp
);
   import osrx_pkg::*;

   // two most recent quantum samples, newest in bit 0
   logic [1:0] hist;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    hist <= 2'b11;
      else if (tick) hist <= {hist[0], line};
   end

   assign prev_smp = hist[0];

   generate
      if (TRI_EN) begin : g_triple
         always_comb begin
            if (tri_mode) begin
               bit_val   = maj3(hist[1], hist[0], line);
               bit_noise = !((hist[1] == hist[0]) && (hist[0] == line));
            end else begin
               bit_val   = line;
               bit_noise = 1'b0;
            end
         end
      end else begin : g_single
         logic unused_tri;
         assign unused_tri = tri_mode ^ hist[1];
         assign bit_val    = line;
         assign bit_noise  = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/osrx_idle.sv
module osrx_idle #(
   parameter int QW = 4,
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          line,
   input  logic          chk_en,
   input  logic [QW-1:0] bit_q_m1,
   input  logic [CW-1:0] target,
   output logic          idle
);
   logic [QW-1:0] q_run;
   logic [CW-1:0] b_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_run <= '0;
         b_run <= '0;
      end else if (tick) begin
         if (!line) begin
            q_run <= '0;
            b_run <= '0;
         end else if (q_run == bit_q_m1) begin
            q_run <= '0;
            if (b_run < target) b_run <= b_run + 1'b1;
         end else begin
            q_run <= q_run + 1'b1;
         end
      end
   end

   assign idle = !chk_en || (b_run >= target);

   a_r8_low_clears_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !line && chk_en) |=> !idle);

endmodule

// File: rtl/osrx_frame.sv
module osrx_frame #(
   parameter int QW  = 4,
   parameter int DW  = 16,
   parameter int FLW = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick,
   input  logic           line,
   input  logic           prev_smp,
   input  logic           bit_val,
   input  logic           bit_noise,
   input  logic [QW-1:0]  bit_q_m1,
   input  logic [QW-1:0]  smp_pt,
   input  logic [FLW-1:0] flen,
   input  logic           par_en,
   output logic           busy_raw,
   output logic           ev_noise,
   output logic           ev_done,
   output logic           ev_fmt,
   output logic [DW-1:0]  data_q
);
   import osrx_pkg::*;

   localparam int BW = FLW + 1;

   osrx_state_e   state;
   logic [QW-1:0] qcnt;
   logic [BW-1:0] bidx;
   logic [BW-1:0] flen_x;
   logic [BW-1:0] stop_idx;
   logic          at_sp;

   assign flen_x   = {1'b0, flen};
   assign stop_idx = flen_x + BW'(1) + {{FLW{1'b0}}, par_en};
   assign at_sp    = tick && (state == ST_RECV) && (qcnt == smp_pt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_HUNT;
         qcnt   <= '0;
         bidx   <= '0;
         data_q <= '0;
      end else if (tick) begin
         case (state)
            ST_HUNT: begin
               if (prev_smp && !line) begin
                  state  <= ST_RECV;
                  qcnt   <= QW'(1);
                  bidx   <= '0;
                  data_q <= '0;
               end
            end
            ST_RECV: begin
               if (qcnt == bit_q_m1) begin
                  qcnt <= '0;
                  bidx <= bidx + 1'b1;
               end else begin
                  qcnt <= qcnt + 1'b1;
               end
               if (qcnt == smp_pt) begin
                  if ((bidx == '0) && bit_val) begin
                     state <= ST_HUNT;
                  end else if (bidx == stop_idx) begin
                     state <= ST_HUNT;
                  end else begin
                     for (int i = 0; i < DW; i++) begin
                        if ((bidx == BW'(i + 1)) && (flen_x >= BW'(i + 1)))
                           data_q[i] <= bit_val;
                     end
                  end
               end
            end
            default: state <= ST_HUNT;
         endcase
      end
   end

   assign busy_raw = (state == ST_RECV);
   assign ev_noise = at_sp && bit_noise;
   assign ev_done  = at_sp && (bidx == stop_idx);
   assign ev_fmt   = ev_done && !bit_val;

   a_r7_start_from_hunt: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_raw) |-> $past(tick && prev_smp && !line));

endmodule

// File: rtl/osrx_receiver.sv
module osrx_receiver #(
   parameter int QW     = 4,
   parameter int DW     = 16,
   parameter int FLW    = $clog2(DW + 1),
   parameter bit TRI_EN = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           q_tick,
   input  logic           rx_line,
   input  logic           cfg_triple,
   input  logic [QW-1:0]  cfg_smp_pt,
   input  logic [QW-1:0]  cfg_bit_q_m1,
   input  logic [FLW-1:0] cfg_flen,
   input  logic           cfg_par_en,
   input  logic           cfg_idle_chk,
   input  logic           cfg_busy_en,
   input  logic           en_noise,
   input  logic           en_fmt,
   input  logic           en_fin,
   output logic [DW-1:0]  rx_data,
   output logic           rx_valid,
   output logic           bus_idle,
   output logic           busy,
   output logic           noise_pulse,
   output logic           fmt_err_pulse,
   output logic           fin_pulse
);
   localparam int CW = FLW + 1;

   generate
      if (QW < 2) begin : g_bad_qw
         $error("QW must allow at least 3 quanta per bit");
      end
      if (DW >= (1 << FLW)) begin : g_bad_flw
         $error("FLW too narrow to hold DW");
      end
   endgenerate

   logic          s_bit, s_noise, s_prev;
   logic          f_busy, f_noise, f_done, f_fmt;
   logic [DW-1:0] f_data;
   logic [CW-1:0] idle_target;

   assign idle_target = {1'b0, cfg_flen} + CW'(2) + {{FLW{1'b0}}, cfg_par_en};

   osrx_sampler #(.TRI_EN(TRI_EN)) sampler_i (
      .clk(clk), .rst_n(rst_n), .tick(q_tick), .line(rx_line),
      .tri_mode(cfg_triple), .bit_val(s_bit), .bit_noise(s_noise),
      .prev_smp(s_prev)
   );

   osrx_frame #(.QW(QW), .DW(DW), .FLW(FLW)) frame_i (
      .clk(clk), .rst_n(rst_n), .tick(q_tick), .line(rx_line),
      .prev_smp(s_prev), .bit_val(s_bit), .bit_noise(s_noise),
      .bit_q_m1(cfg_bit_q_m1), .smp_pt(cfg_smp_pt), .flen(cfg_flen),
      .par_en(cfg_par_en), .busy_raw(f_busy), .ev_noise(f_noise),
      .ev_done(f_done), .ev_fmt(f_fmt), .data_q(f_data)
   );

   osrx_idle #(.QW(QW), .CW(CW)) idle_i (
      .clk(clk), .rst_n(rst_n), .tick(q_tick), .line(rx_line),
      .chk_en(cfg_idle_chk), .bit_q_m1(cfg_bit_q_m1),
      .target(idle_target), .idle(bus_idle)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data       <= '0;
         rx_valid      <= 1'b0;
         noise_pulse   <= 1'b0;
         fmt_err_pulse <= 1'b0;
         fin_pulse     <= 1'b0;
      end else begin
         rx_valid      <= f_done;
         noise_pulse   <= f_noise && en_noise;
         fmt_err_pulse <= f_fmt && en_fmt;
         fin_pulse     <= f_done && en_fin;
         if (f_done) rx_data <= f_data;
      end
   end

   assign busy = cfg_busy_en && f_busy;

   a_r5_valid_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(q_tick));
   a_r4_fmt_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_err_pulse |-> rx_valid);
   a_r11_noise_gated: assert property (@(posedge clk) disable iff (!rst_n)
      noise_pulse |-> $past(en_noise));
   a_r3_single_no_noise: assert property (@(posedge clk) disable iff (!rst_n)
      noise_pulse |-> $past(cfg_triple));
   a_r10_busy_before_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && $past(cfg_busy_en)) |-> $past(busy));

endmodule

// File: tb/osrx_receiver_tb_top.sv
module osrx_receiver_tb_top;
   localparam int QW  = 4;
   localparam int DW  = 16;
   localparam int FLW = 5;
   localparam int NQ  = 8;
   localparam int SP  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic q_tick = 1'b0;
   logic rx_line = 1'b1;
   logic cfg_triple = 1'b0;
   logic [QW-1:0] cfg_smp_pt = QW'(SP);
   logic [QW-1:0] cfg_bit_q_m1 = QW'(NQ - 1);
   logic [FLW-1:0] cfg_flen = FLW'(8);
   logic cfg_par_en = 1'b0;
   logic cfg_idle_chk = 1'b1;
   logic cfg_busy_en = 1'b1;
   logic en_noise = 1'b1, en_fmt = 1'b1, en_fin = 1'b1;
   logic [DW-1:0] rx_data;
   logic rx_valid, bus_idle, busy, noise_pulse, fmt_err_pulse, fin_pulse;

   always #10 clk = ~clk;

   osrx_receiver #(.QW(QW), .DW(DW), .FLW(FLW)) dut_i (
      .clk(clk), .rst_n(rst_n), .q_tick(q_tick), .rx_line(rx_line),
      .cfg_triple(cfg_triple), .cfg_smp_pt(cfg_smp_pt),
      .cfg_bit_q_m1(cfg_bit_q_m1), .cfg_flen(cfg_flen),
      .cfg_par_en(cfg_par_en), .cfg_idle_chk(cfg_idle_chk),
      .cfg_busy_en(cfg_busy_en), .en_noise(en_noise), .en_fmt(en_fmt),
      .en_fin(en_fin), .rx_data(rx_data), .rx_valid(rx_valid),
      .bus_idle(bus_idle), .busy(busy), .noise_pulse(noise_pulse),
      .fmt_err_pulse(fmt_err_pulse), .fin_pulse(fin_pulse)
   );

   int checks = 0, failures = 0;
   int tdiv = 1;
   int n_valid = 0, n_noise = 0, n_fmt = 0, n_fin = 0, n_split = 0;
   logic [DW-1:0] last_data = '0;
   logic busy_mid = 1'b0;
   int cycles = 0;

   always @(negedge clk) begin
      cycles <= cycles + 1;
      if (rx_valid) begin
         n_valid <= n_valid + 1;
         last_data <= rx_data;
      end
      if (noise_pulse) n_noise <= n_noise + 1;
      if (fmt_err_pulse) n_fmt <= n_fmt + 1;
      if (fin_pulse) n_fin <= n_fin + 1;
      if (fmt_err_pulse && !fin_pulse && en_fin) n_split <= n_split + 1;
   end

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic quantum(input logic v);
      for (int k = 0; k < tdiv; k++) begin
         @(negedge clk);
         rx_line = v;
         q_tick = (k == tdiv - 1);
      end
      @(posedge clk);
      #1 q_tick = 1'b0;
   endtask

   // gb = bit index to glitch (-1 none), gq = quantum within it
   task automatic send_frame(input logic [DW-1:0] d, input int fl, input logic par,
                             input int gb, input int gq, input logic stopv);
      int nb;
      logic v;
      nb = fl + 2 + int'(par);
      for (int b = 0; b < nb; b++) begin
         if (b == 0) v = 1'b0;
         else if (b <= fl) v = d[b-1];
         else if (par && b == fl + 1) v = ^d;
         else v = stopv;
         for (int q = 0; q < NQ; q++) quantum(v ^ ((b == gb) && (q == gq)));
         if (b == 2) busy_mid = busy;
      end
      quantum(1'b1);
      quantum(1'b1);
      quantum(1'b1);
   endtask

   int v0, nz0, f0, fn0;
   task automatic snap();
      @(negedge clk);
      v0 = n_valid; nz0 = n_noise; f0 = n_fmt; fn0 = n_fin;
   endtask

   function automatic logic [DW-1:0] mask(input int fl);
      return DW'((32'h1 << fl) - 1);
   endfunction

   initial begin
      #100;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R5 reset rx_valid", rx_valid, 0);
      check("R10 reset busy", busy, 0);
      check("R8 reset idle", bus_idle, 0);
      check("R11 reset pulses", {noise_pulse, fmt_err_pulse, fin_pulse}, 0);

      // R9
      cfg_idle_chk = 1'b0;
      #1 check("R9 idle forced", bus_idle, 1);
      quantum(1'b0);
      check("R9 idle forced with low line", bus_idle, 1);
      cfg_idle_chk = 1'b1;

      // R8 without and with parity
      for (int p = 0; p < 2; p++) begin
         int tgt;
         cfg_par_en = p[0];
         tgt = (8 + 2 + p) * NQ;
         quantum(1'b0);
         #1 check("R8 low clears idle", bus_idle, 0);
         for (int i = 0; i < tgt - 1; i++) quantum(1'b1);
         check("R8 idle not early", bus_idle, 0);
         quantum(1'b1);
         check("R8 idle at count", bus_idle, 1);
      end
      cfg_par_en = 1'b0;

      // R5 R1 sweep: single mode, 8 bits, all values
      cfg_triple = 1'b0;
      for (int d = 0; d < 256; d++) begin
         snap();
         send_frame(DW'(d), 8, 1'b0, -1, 0, 1'b1);
         check("R5 one valid", n_valid - v0, 1);
         check("R5 data", last_data, DW'(d));
         check("R3 single no noise", n_noise - nz0, 0);
      end

      // R2 R3 sweep: triple mode, one glitch per frame at SP-1
      cfg_triple = 1'b1;
      for (int d = 0; d < 256; d++) begin
         snap();
         send_frame(DW'(d), 8, 1'b0, (d % 8) + 1, SP - 1, 1'b1);
         check("R2 majority data", last_data, DW'(d));
         check("R3 noise flagged", n_noise - nz0, 1);
      end
      snap();
      send_frame(16'h0055, 8, 1'b0, 3, SP - 2, 1'b1);
      check("R2 glitch at sp-2", last_data, 16'h0055);
      snap();
      send_frame(16'h0055, 8, 1'b0, 3, SP + 1, 1'b1);
      check("R3 glitch outside window", n_noise - nz0, 0);
      check("R2 glitch outside window data", last_data, 16'h0055);

      // R6 length sweep with quantum tick every other clock
      tdiv = 2;
      cfg_triple = 1'b0;
      for (int p = 0; p < 2; p++) begin
         for (int fl = 1; fl <= DW; fl++) begin
            cfg_par_en = p[0];
            cfg_flen = FLW'(fl);
            snap();
            send_frame(16'hA5C3, fl, p[0], -1, 0, 1'b1);
            check("R6 frame count", n_valid - v0, 1);
            check("R6 data with length", last_data, 16'hA5C3 & mask(fl));
            check("R4 no fmt on good frame", n_fmt - f0, 0);
         end
      end
      tdiv = 1;
      cfg_par_en = 1'b0;
      cfg_flen = FLW'(8);

      // R1 single sample point
      snap();
      send_frame(16'h0000, 8, 1'b0, 1, SP, 1'b1);
      check("R1 sample point taken", last_data, 16'h0001);
      check("R3 single glitch no noise", n_noise - nz0, 0);
      snap();
      send_frame(16'h0000, 8, 1'b0, 1, SP - 1, 1'b1);
      check("R1 off-point ignored", last_data, 16'h0000);

      // R4 bad stop, with noise in same stop decision too
      cfg_triple = 1'b1;
      snap();
      send_frame(16'h003C, 8, 1'b0, -1, 0, 1'b0);
      check("R4 fmt error", n_fmt - f0, 1);
      check("R4 fin with fmt", n_fin - fn0, 1);
      check("R4 valid with fmt", n_valid - v0, 1);
      snap();
      send_frame(16'h003C, 8, 1'b0, 9, SP, 1'b1);
      check("R4 noisy good stop no fmt", n_fmt - f0, 0);
      check("R3 noisy stop noise", n_noise - nz0, 1);
      check("R4 fmt and fin never split", n_split, 0);

      // R11 gating
      en_fmt = 1'b0;
      snap();
      send_frame(16'h0011, 8, 1'b0, -1, 0, 1'b0);
      check("R11 fmt gated", n_fmt - f0, 0);
      check("R11 fin still", n_fin - fn0, 1);
      en_fmt = 1'b1;
      en_fin = 1'b0;
      snap();
      send_frame(16'h0022, 8, 1'b0, -1, 0, 1'b1);
      check("R11 fin gated", n_fin - fn0, 0);
      check("R11 valid ungated", n_valid - v0, 1);
      en_fin = 1'b1;
      en_noise = 1'b0;
      snap();
      send_frame(16'h0033, 8, 1'b0, 2, SP - 1, 1'b1);
      check("R11 noise gated", n_noise - nz0, 0);
      en_noise = 1'b1;

      // R7 false start
      cfg_triple = 1'b0;
      snap();
      for (int q = 0; q < 3; q++) quantum(1'b0);
      for (int q = 0; q < 3 * NQ; q++) quantum(1'b1);
      check("R7 false start no valid", n_valid - v0, 0);
      check("R7 false start no fin", n_fin - fn0, 0);
      check("R7 busy after drop", busy, 0);

      // R10 busy
      snap();
      send_frame(16'h0077, 8, 1'b0, -1, 0, 1'b1);
      check("R10 busy during frame", busy_mid, 1);
      check("R10 busy after frame", busy, 0);
      cfg_busy_en = 1'b0;
      snap();
      send_frame(16'h0077, 8, 1'b0, -1, 0, 1'b1);
      check("R10 busy disabled", busy_mid, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      wait (cycles > 190000);
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule